// File: doc/BRIEF.md
# Region Prefetch Engine with Line Buffer

This block sits beside a processor's second-level cache miss path. It tracks how often the processor misses within each coarse region of memory that it holds exclusively. A region is an aligned group of `LPR` consecutive cache lines. When a region collects `THRESH` such misses, the demand request that reached the count carries a prefetch mask to memory. The mask names the other lines of that region that are worth fetching. The prefetch is only ever attached to a demand request for a region that no other processor shares. It is never sent as a broadcast.

Prefetched lines come back on a fill port and are parked in a small line buffer. A later miss to a parked line is answered from the buffer at once instead of going to memory. This happens only when the region check (supplied with the miss) says the region is valid and exclusive. The count for the region then restarts. A per-region record of lines cached since the last prefetch keeps the next prefetch from fetching them again.

The region state array and the memory system sit outside the block. Line addresses are in units of whole lines. The low log2(`LPR`) bits of a line address are the line's offset within its region, and the remaining upper bits are the region number.

Handshake rules: `mreq` and `rsp` are valid/ready outputs. The valid signal never depends on the ready that answers it. `miss_ready` mirrors the ready of whichever output the current miss is routed to. The requester must hold `miss_line` and `miss_excl` stable while `miss_valid` is high and `miss_ready` is low. The fill port is always ready.

Top module: `rpf_engine`

## Requirements
- R1: After reset, `mreq_valid` and `rsp_valid` are low and `fill_ready` is high.
- R2: Exclusive misses sent to memory are counted per region. The miss that brings the count to `THRESH` (default 2) carries in `mreq_pf_mask` the region's other lines, where bit o stands for offset o. With default parameters, misses to offsets 0 then 1 give mask 4'b1100 on the second request and mask 0 on the first.
- R3: A miss with `miss_excl` low goes to memory with `mreq_bcast` high and a zero mask, and it does not count toward the threshold.
- R4: The prefetch mask leaves out the demand line, lines still awaited from an earlier prefetch, lines parked in the buffer, and lines cached since the last prefetch. A line counts as cached once it is sent to memory as a demand miss or taken from the buffer.
- R5: After a prefetch fires, the region's count restarts from zero. A fresh `THRESH` exclusive misses fire the next one, even when the resulting mask is empty.
- R6: A fill for a line that an outstanding prefetch is awaiting is stored in the buffer. A fill for any other line is dropped.
- R7: An exclusive miss to a parked line is answered on `rsp` with the stored data and issues no memory request, and the entry is freed. With `miss_excl` low, the same miss goes to memory as a broadcast, and the parked line stays.
- R8: An exclusive miss to a line still awaited from a prefetch is stalled (`miss_ready`, `mreq_valid`, `rsp_valid` all low) until its fill arrives.
- R9: An `inv_valid` pulse for a region drops that region's parked lines and its count, mask and awaited lines.
- R10: A fill that finds the buffer full replaces the entry that has been parked longest.
- R11: While the chosen output's ready is low, its valid stays high and `miss_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand miss present |
| miss_ready | output | 1 | Miss accepted this cycle |
| miss_line | input | LA_W | Line address of the miss |
| miss_excl | input | 1 | Region valid and held exclusively (no broadcast needed) |
| mreq_valid | output | 1 | Request to memory present |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_line | output | LA_W | Demand line address |
| mreq_bcast | output | 1 | Request must be broadcast |
| mreq_pf_mask | output | LPR | Region offsets to prefetch with this request |
| rsp_valid | output | 1 | Buffer-hit data for the cache present |
| rsp_ready | input | 1 | Cache accepts the data |
| rsp_line | output | LA_W | Line address of the returned data |
| rsp_data | output | DATA_W | Line data from the buffer |
| fill_valid | input | 1 | Prefetched line returning from memory |
| fill_ready | output | 1 | Always high |
| fill_line | input | LA_W | Line address of the fill |
| fill_data | input | DATA_W | Fill data |
| inv_valid | input | 1 | Region evicted or lost exclusivity |
| inv_region | input | LA_W-log2(LPR) | Region number to drop |

## Verification
The assertions take for granted that memory returns only lines it was asked to prefetch, and at most once each. This is what keeps a buffered line unique. They also assume the requester holds a stalled miss steady. The bench model answers each prefetch exactly once, in the order requested, and never fills a line twice. The one stray fill it sends is for a region with no awaited lines, which the block must drop. Inputs are changed only just after a rising edge and held until the handshake completes.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  typedef enum logic {BE_EMPTY = 1'b0, BE_READY = 1'b1} buf_state_e;
endpackage

// File: rtl/rpf_tracker.sv
module rpf_tracker #(
  parameter int REG_W   = 10,
  parameter int LPR     = 4,
  parameter int THRESH  = 2,
  parameter int ENTRIES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_W-1:0]         m_reg,
  input  logic [$clog2(LPR)-1:0]   m_off,
  input  logic [LPR-1:0]           m_present,
  input  logic                     m_go,
  input  logic                     m_take,
  output logic [LPR-1:0]           pf_mask,
  output logic                     pend_hit,
  input  logic                     f_valid,
  input  logic [REG_W-1:0]         f_reg,
  input  logic [$clog2(LPR)-1:0]   f_off,
  output logic                     f_keep,
  input  logic                     i_valid,
  input  logic [REG_W-1:0]         i_reg
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(THRESH + 1);

  typedef struct packed {
    logic             vld;
    logic [REG_W-1:0] rid;
    logic [CNT_W-1:0] cnt;
    logic [LPR-1:0]   seen;
    logic [LPR-1:0]   pend;
  } trk_t;

  trk_t tab [ENTRIES];
  trk_t nxt [ENTRIES];

  logic [IDX_W-1:0] mi, fi, vi;
  logic             m_match, f_match, fire;
  logic [CNT_W-1:0] cnt_new;
  logic [LPR-1:0]   line_bit, base;

  always_comb begin
    mi       = m_reg[IDX_W-1:0];
    fi       = f_reg[IDX_W-1:0];
    vi       = i_reg[IDX_W-1:0];
    m_match  = tab[mi].vld && (tab[mi].rid == m_reg);
    line_bit = LPR'(1) << m_off;
    cnt_new  = m_match ? tab[mi].cnt + CNT_W'(1) : CNT_W'(1);
    fire     = cnt_new >= CNT_W'(THRESH);
    base     = line_bit | m_present | (m_match ? (tab[mi].seen | tab[mi].pend) : '0);
    pf_mask  = fire ? ~base : '0;
    pend_hit = m_match && tab[mi].pend[m_off];
    f_match  = f_valid && tab[fi].vld && (tab[fi].rid == f_reg) && tab[fi].pend[f_off];
    f_keep   = f_match && !(i_valid && (i_reg == f_reg));
  end

  always_comb begin
    for (int k = 0; k < ENTRIES; k++) nxt[k] = tab[k];
    if (m_go) begin
      nxt[mi].vld  = 1'b1;
      nxt[mi].rid  = m_reg;
      nxt[mi].cnt  = fire ? '0 : cnt_new;
      nxt[mi].seen = fire ? line_bit : ((m_match ? tab[mi].seen : '0) | line_bit);
      nxt[mi].pend = (m_match ? tab[mi].pend : '0) | pf_mask;
    end
    if (m_take && m_match) nxt[mi].seen = tab[mi].seen | line_bit;
    if (f_match && (nxt[fi].rid == f_reg)) nxt[fi].pend[f_off] = 1'b0;
    if (i_valid && (nxt[vi].rid == i_reg)) nxt[vi].vld = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) tab[k] <= '0;
    end else begin
      for (int k = 0; k < ENTRIES; k++) tab[k] <= nxt[k];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    AST_COUNT_REARMED: assert property (@(posedge clk) disable iff (!rst_n)
      tab[g].cnt < CNT_W'(THRESH)); // R5
  end

  AST_PF_AVOIDS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    m_go && m_match |-> ((pf_mask & tab[mi].pend) == '0)); // R4
endmodule

// File: rtl/rpf_buffer.sv
module rpf_buffer
  import rpf_pkg::*;
#(
  parameter int LA_W   = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int LPR    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LA_W-1:0]               q_line,
  output logic                          hit,
  output logic [DATA_W-1:0]             hit_data,
  output logic [LPR-1:0]                present,
  input  logic                          take,
  input  logic                          w_en,
  input  logic [LA_W-1:0]               w_line,
  input  logic [DATA_W-1:0]             w_data,
  input  logic                          i_valid,
  input  logic [LA_W-$clog2(LPR)-1:0]   i_reg
);
  localparam int OFF_W = $clog2(LPR);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AGE_W = $clog2(DEPTH) + 2;

  buf_state_e        st   [DEPTH];
  logic [LA_W-1:0]   line [DEPTH];
  logic [DATA_W-1:0] data [DEPTH];
  logic [AGE_W-1:0]  age  [DEPTH];

  logic [DEPTH-1:0] match, wmatch;
  logic [IDX_W-1:0] hit_idx, vic;
  logic             found;

  always_comb begin
    hit_idx = '0;
    hit     = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      match[k]  = (st[k] == BE_READY) && (line[k] == q_line);
      wmatch[k] = (st[k] == BE_READY) && (line[k] == w_line);
      if (match[k] && !hit) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(k);
      end
    end
    hit_data = data[hit_idx];
    for (int o = 0; o < LPR; o++) begin
      present[o] = 1'b0;
      for (int k = 0; k < DEPTH; k++)
        if ((st[k] == BE_READY) && (line[k] == {q_line[LA_W-1:OFF_W], OFF_W'(o)}))
          present[o] = 1'b1;
    end
  end

  // victim: first empty slot, else the longest-parked entry (lowest index on a tie)
  always_comb begin
    vic   = '0;
    found = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if (!found && (st[k] == BE_EMPTY)) begin
        vic   = IDX_W'(k);
        found = 1'b1;
      end
    if (!found)
      for (int k = 0; k < DEPTH; k++)
        if (age[k] > age[vic]) vic = IDX_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        st[k]   <= BE_EMPTY;
        line[k] <= '0;
        data[k] <= '0;
        age[k]  <= '0;
      end
    end else begin
      if (take) st[hit_idx] <= BE_EMPTY;
      if (w_en) begin
        for (int k = 0; k < DEPTH; k++)
          if ((st[k] == BE_READY) && (age[k] != '1)) age[k] <= age[k] + AGE_W'(1);
        st[vic]   <= BE_READY;
        line[vic] <= w_line;
        data[vic] <= w_data;
        age[vic]  <= '0;
      end
      if (i_valid)
        for (int k = 0; k < DEPTH; k++)
          if ((st[k] == BE_READY) && (line[k][LA_W-1:OFF_W] == i_reg) &&
              !(w_en && (IDX_W'(k) == vic)))
            st[k] <= BE_EMPTY;
    end
  end

  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1); // R6
  AST_FILL_IS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |-> (wmatch == '0)); // R6
  AST_TAKE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hit); // R7
endmodule

// File: rtl/rpf_engine.sv
module rpf_engine #(
  parameter int LA_W        = 12,
  parameter int DATA_W      = 32,
  parameter int LPR         = 4,
  parameter int THRESH      = 2,
  parameter int BUF_DEPTH   = 4,
  parameter int TRK_ENTRIES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         miss_valid,
  output logic                         miss_ready,
  input  logic [LA_W-1:0]              miss_line,
  input  logic                         miss_excl,
  output logic                         mreq_valid,
  input  logic                         mreq_ready,
  output logic [LA_W-1:0]              mreq_line,
  output logic                         mreq_bcast,
  output logic [LPR-1:0]               mreq_pf_mask,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [LA_W-1:0]              rsp_line,
  output logic [DATA_W-1:0]            rsp_data,
  input  logic                         fill_valid,
  output logic                         fill_ready,
  input  logic [LA_W-1:0]              fill_line,
  input  logic [DATA_W-1:0]            fill_data,
  input  logic                         inv_valid,
  input  logic [LA_W-$clog2(LPR)-1:0]  inv_region
);
  localparam int OFF_W = $clog2(LPR);
  localparam int REG_W = LA_W - OFF_W;

  logic           buf_hit, pend_hit, f_keep, wait_pend, hit_ok, go, take;
  logic [LPR-1:0] present, pf_mask;

  assign wait_pend    = miss_excl && pend_hit;
  assign hit_ok       = miss_excl && buf_hit && !wait_pend;
  assign rsp_valid    = miss_valid && hit_ok;
  assign rsp_line     = miss_line;
  assign mreq_valid   = miss_valid && !hit_ok && !wait_pend;
  assign mreq_line    = miss_line;
  assign mreq_bcast   = !miss_excl;
  assign mreq_pf_mask = miss_excl ? pf_mask : '0;
  assign miss_ready   = wait_pend ? 1'b0 : (hit_ok ? rsp_ready : mreq_ready);
  assign take         = rsp_valid && rsp_ready;
  assign go           = mreq_valid && mreq_ready && miss_excl;
  assign fill_ready   = 1'b1;

  rpf_tracker #(.REG_W(REG_W), .LPR(LPR), .THRESH(THRESH), .ENTRIES(TRK_ENTRIES)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .m_reg(miss_line[LA_W-1:OFF_W]), .m_off(miss_line[OFF_W-1:0]),
    .m_present(present), .m_go(go), .m_take(take),
    .pf_mask(pf_mask), .pend_hit(pend_hit),
    .f_valid(fill_valid), .f_reg(fill_line[LA_W-1:OFF_W]), .f_off(fill_line[OFF_W-1:0]),
    .f_keep(f_keep), .i_valid(inv_valid), .i_reg(inv_region)
  );

  rpf_buffer #(.LA_W(LA_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .LPR(LPR)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .q_line(miss_line), .hit(buf_hit), .hit_data(rsp_data), .present(present),
    .take(take), .w_en(f_keep), .w_line(fill_line), .w_data(fill_data),
    .i_valid(inv_valid), .i_reg(inv_region)
  );

  AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && wait_pend |-> !mreq_valid && !rsp_valid && !miss_ready); // R8
  AST_HIT_IS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> miss_excl && !mreq_valid); // R7
  AST_PF_NEVER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && (mreq_pf_mask != '0) |-> !mreq_bcast); // R3
  AST_PF_SKIPS_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> !mreq_pf_mask[miss_line[OFF_W-1:0]]); // R4
  AST_MREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready && $stable(miss_line) && $stable(miss_excl) && miss_valid
      |=> mreq_valid || !miss_valid || !$stable(miss_line)); // R11
endmodule

// File: tb/tb_rpf_engine.sv
`timescale 1ns/1ps
module tb_rpf_engine;
  localparam int LA_W = 12;
  localparam int DW   = 32;
  localparam int LPR  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            miss_valid = 1'b0, miss_excl = 1'b0;
  logic [LA_W-1:0] miss_line = '0;
  logic            miss_ready;
  logic            mreq_valid, mreq_bcast;
  logic            mreq_ready = 1'b1;
  logic [LA_W-1:0] mreq_line;
  logic [LPR-1:0]  mreq_pf_mask;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [LA_W-1:0] rsp_line;
  logic [DW-1:0]   rsp_data;
  logic            fill_valid = 1'b0;
  logic            fill_ready;
  logic [LA_W-1:0] fill_line = '0;
  logic [DW-1:0]   fill_data = '0;
  logic            inv_valid = 1'b0;
  logic [LA_W-3:0] inv_region = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit              is_rsp;
    logic [LA_W-1:0] line;
    logic            bcast;
    logic [LPR-1:0]  pf;
    logic [DW-1:0]   data;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  rpf_engine dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line), .miss_excl(miss_excl),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_line(mreq_line),
    .mreq_bcast(mreq_bcast), .mreq_pf_mask(mreq_pf_mask),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_line(rsp_line), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line), .fill_data(fill_data),
    .inv_valid(inv_valid), .inv_region(inv_region)
  );

  function automatic logic [DW-1:0] line_data(input logic [LA_W-1:0] l);
    return 32'hD0000000 | (32'(l) * 32'h00010101);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: compare each completed output handshake against the queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ((mreq_valid && mreq_ready) || (rsp_valid && rsp_ready)) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7", "unexpected output", {20'h0, mreq_valid ? mreq_line : rsp_line}, '0);
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(rsp_valid == e.is_rsp, t, "rsp-vs-mreq kind", 32'(rsp_valid), 32'(e.is_rsp));
          if (e.is_rsp) begin
            check(rsp_line == e.line, t, "rsp_line", 32'(rsp_line), 32'(e.line));
            check(rsp_data == e.data, t, "rsp_data", rsp_data, e.data);
          end else begin
            check(mreq_line == e.line, t, "mreq_line", 32'(mreq_line), 32'(e.line));
            check(mreq_bcast == e.bcast, t, "mreq_bcast", 32'(mreq_bcast), 32'(e.bcast));
            check(mreq_pf_mask == e.pf, t, "mreq_pf_mask", 32'(mreq_pf_mask), 32'(e.pf));
          end
        end
      end
    end
  end

  task automatic push(input bit is_rsp, input logic [LA_W-1:0] l, input logic b,
                      input logic [LPR-1:0] pf, input string tag);
    exp_t e;
    e.is_rsp = is_rsp; e.line = l; e.bcast = b; e.pf = pf; e.data = line_data(l);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic do_miss(input logic [LA_W-1:0] l, input logic ex);
    @(posedge clk); #2;
    miss_valid = 1'b1; miss_line = l; miss_excl = ex;
    do @(negedge clk); while (!miss_ready);
    @(posedge clk); #2;
    miss_valid = 1'b0;
  endtask

  task automatic expect_mreq(input logic [LA_W-1:0] l, input logic ex,
                             input logic [LPR-1:0] pf, input string tag);
    push(1'b0, l, !ex, pf, tag);
    do_miss(l, ex);
  endtask

  task automatic expect_rsp(input logic [LA_W-1:0] l, input string tag);
    push(1'b1, l, 1'b0, '0, tag);
    do_miss(l, 1'b1);
  endtask

  task automatic fill(input logic [LA_W-1:0] l);
    @(posedge clk); #2;
    fill_valid = 1'b1; fill_line = l; fill_data = line_data(l);
    @(posedge clk); #2;
    fill_valid = 1'b0;
  endtask

  task automatic invalidate(input logic [LA_W-3:0] r);
    @(posedge clk); #2;
    inv_valid = 1'b1; inv_region = r;
    @(posedge clk); #2;
    inv_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!mreq_valid, "R1", "mreq_valid in reset", 32'(mreq_valid), 0);
    check(!rsp_valid, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    check(fill_ready, "R1", "fill_ready in reset", 32'(fill_ready), 1);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    check(!mreq_valid && !rsp_valid, "R1", "outputs idle after reset", 32'(mreq_valid), 0);

    // region 4: threshold of two misses, prefetch the other two lines (R2)
    expect_mreq(12'h010, 1'b1, 4'b0000, "R2");
    expect_mreq(12'h011, 1'b1, 4'b1100, "R2");

    // miss to an awaited line stalls (R8)
    @(posedge clk); #2;
    miss_valid = 1'b1; miss_line = 12'h012; miss_excl = 1'b1;
    repeat (2) @(negedge clk);
    check(!miss_ready, "R8", "miss_ready while awaited", 32'(miss_ready), 0);
    check(!mreq_valid && !rsp_valid, "R8", "no output while awaited", 32'(mreq_valid | rsp_valid), 0);
    @(posedge clk); #2; miss_valid = 1'b0;

    fill(12'h012);
    fill(12'h013);
    expect_rsp(12'h012, "R7");                         // buffer hit, entry freed
    expect_mreq(12'h012, 1'b1, 4'b0000, "R5");         // count restarted: 1st miss
    expect_mreq(12'h010, 1'b1, 4'b0000, "R4");         // 2nd miss fires, all lines excluded

    // regions 5 and 6 fill the buffer; the fourth fill evicts 0x13 (R10)
    expect_mreq(12'h014, 1'b1, 4'b0000, "R2");
    expect_mreq(12'h015, 1'b1, 4'b1100, "R2");
    fill(12'h016);
    fill(12'h017);
    expect_mreq(12'h018, 1'b1, 4'b0000, "R2");
    expect_mreq(12'h019, 1'b1, 4'b1100, "R2");
    fill(12'h01A);
    fill(12'h01B);
    expect_mreq(12'h013, 1'b1, 4'b0000, "R10");        // oldest entry was replaced
    expect_rsp(12'h016, "R10");                        // younger entry kept

    // re-prefetch of region 4 skips lines cached since last prefetch (R4, R5)
    expect_mreq(12'h011, 1'b1, 4'b0100, "R4");
    fill(12'h012);
    invalidate(10'h004);
    expect_mreq(12'h012, 1'b1, 4'b0000, "R9");         // parked line dropped

    // non-exclusive miss ignores the parked line and broadcasts (R7, R3)
    expect_mreq(12'h017, 1'b0, 4'b0000, "R7");
    expect_rsp(12'h017, "R7");

    // region 7: non-exclusive misses do not count (R3)
    expect_mreq(12'h01C, 1'b0, 4'b0000, "R3");
    expect_mreq(12'h01D, 1'b0, 4'b0000, "R3");
    expect_mreq(12'h01E, 1'b1, 4'b0000, "R3");
    expect_mreq(12'h01F, 1'b1, 4'b0011, "R3");

    // back-pressure on rsp (R11)
    rsp_ready = 1'b0;
    push(1'b1, 12'h01A, 1'b0, '0, "R11");
    @(posedge clk); #2;
    miss_valid = 1'b1; miss_line = 12'h01A; miss_excl = 1'b1;
    repeat (2) @(negedge clk);
    check(rsp_valid && !miss_ready, "R11", "rsp held under back-pressure",
          {rsp_valid, miss_ready}, 32'b10);
    @(posedge clk); #2; rsp_ready = 1'b1;
    @(posedge clk); #2; miss_valid = 1'b0;

    // stray fill dropped (R6), then back-pressure on mreq (R11)
    fill(12'h02C);
    mreq_ready = 1'b0;
    push(1'b0, 12'h02C, 1'b0, 4'b0000, "R6");
    @(posedge clk); #2;
    miss_valid = 1'b1; miss_line = 12'h02C; miss_excl = 1'b1;
    repeat (2) @(negedge clk);
    check(mreq_valid && !miss_ready, "R11", "mreq held under back-pressure",
          {mreq_valid, miss_ready}, 32'b10);
    @(posedge clk); #2; mreq_ready = 1'b1;
    @(posedge clk); #2; miss_valid = 1'b0;

    repeat (3) @(posedge clk);
    check(expq.size() == 0, "R2", "outstanding expectations", expq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule